// File: doc/BRIEF.md
# Thermal Throttle and Critical Shutdown Monitor

This block watches a digital junction-temperature code and guards the chip at two levels. If the reading reaches a programmable trip level, the block stops the core clock for part of every period. The period and the number of enabled cycles in it are both programmable. If the reading reaches a higher critical level, the block raises a shutdown request. That request holds until reset.

Software can also force throttling with a request input, whatever the temperature. The hardware comparison acts on its own as a fast fail-safe. A hot flag is high while throttling is active. The trip comparison has a fixed hysteresis band, so throttling ends only once the reading drops clearly below the trip level. The trip and critical levels are inputs driven from registers, because they are calibrated per part.

Top module: `thermal_throttle`

## Requirements
- R1: After reset, coreClkEn is 1, procHot is 0 and shutdownReq is 0.
- R2: When tempCode >= tripLevel is sampled at a clock edge, procHot is 1 after that edge.
- R3: Once hot, procHot stays 1 while tempCode + HYST >= tripLevel (HYST = 4 by default). It falls to 0 after the first edge at which tempCode + HYST < tripLevel, provided swThrottle is 0.
- R4: While throttled, coreClkEn follows a repeating pattern of periodLen cycles. The first edge of throttling is cycle 0 of the pattern. Within each period, coreClkEn is 1 for cycles 0 to onLen-1 and 0 for the rest.
- R5: While procHot is 0 and shutdownReq is 0, coreClkEn is constantly 1.
- R6: swThrottle = 1 sampled at an edge makes procHot 1 after that edge, and starts the R4 pattern at any temperature.
- R7: When tempCode >= critLevel is sampled at an edge, shutdownReq is 1 after that edge. It then stays 1, even when the temperature falls, until reset.
- R8: While shutdownReq is 1, coreClkEn is 0. This overrides both throttling and the idle state.
- R9: If onLen >= periodLen, coreClkEn stays 1 while throttled. If onLen = 0, it stays 0 while throttled.
- R10: tripLevel takes effect as soon as it changes. A reading that is hot against a low trip level is released once the trip level is raised above reading + HYST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempCode | input | TEMP_W | Current junction-temperature code |
| tripLevel | input | TEMP_W | Calibrated throttle trip level |
| critLevel | input | TEMP_W | Critical shutdown level |
| periodLen | input | CNT_W | Throttle period in cycles (0 and 1 both mean one cycle) |
| onLen | input | CNT_W | Enabled cycles per throttle period |
| swThrottle | input | 1 | Software throttle request |
| coreClkEn | output | 1 | Core clock enable |
| procHot | output | 1 | Throttling active |
| shutdownReq | output | 1 | Sticky critical shutdown request |

## Verification
Two events can land on the same edge: the start of throttling and a critical shutdown. The bench provokes this by raising the temperature past both levels in one step. It then checks that procHot and shutdownReq rise together on that edge, and that coreClkEn reads 0 at once instead of showing the first enabled cycle of the duty pattern. It also checks that the clock enable stays off after the temperature falls again, while the duty counter would otherwise still run.

// File: rtl/thr_pkg.sv
package thr_pkg;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic thrActive;  // duty pattern applies
    logic cntClear;   // hold phase counter at zero
    logic stopAll;    // critical stop, enable forced low
  } thrStrobe_t;

  typedef enum logic [0:0] {
    ST_COOL = 1'b0,
    ST_HOT  = 1'b1
  } hotState_t;

endpackage

// File: rtl/thr_datapath.sv
module thr_datapath
  import thr_pkg::*;
#(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HYST   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [TEMP_W-1:0] tripLevel,
  input  logic [TEMP_W-1:0] critLevel,
  input  logic [CNT_W-1:0]  periodLen,
  input  logic [CNT_W-1:0]  onLen,
  input  thrStrobe_t        strobe,
  output logic              atTrip,
  output logic              belowRelease,
  output logic              atCrit,
  output logic              coreClkEn
);

  localparam int unsigned EXT_W = TEMP_W + 1;
  localparam logic [EXT_W-1:0] HYST_EXT = EXT_W'(HYST);

  logic [EXT_W-1:0] tempExt;
  logic [EXT_W-1:0] tripExt;
  logic [CNT_W-1:0] phaseCnt;
  logic             lastPhase;
  logic             phaseOn;

  // Threshold comparators
  always_comb begin
    tempExt      = {1'b0, tempCode};
    tripExt      = {1'b0, tripLevel};
    atTrip       = (tempCode >= tripLevel);
    atCrit       = (tempCode >= critLevel);
    belowRelease = ((tempExt + HYST_EXT) < tripExt);
  end

  // Phase counter for the duty pattern
  always_comb begin
    lastPhase = (periodLen == '0) || (phaseCnt >= (periodLen - CNT_W'(1)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.cntClear) begin
      phaseCnt <= '0;
    end else if (lastPhase) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_comb begin
    phaseOn   = (phaseCnt < onLen);
    coreClkEn = !strobe.stopAll && (!strobe.thrActive || phaseOn);
  end

endmodule

// File: rtl/thr_control.sv
module thr_control
  import thr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       atTrip,
  input  logic       belowRelease,
  input  logic       atCrit,
  input  logic       swThrottle,
  output thrStrobe_t strobe,
  output logic       procHot,
  output logic       shutdownReq
);

  hotState_t hwState;
  hotState_t hwStateNext;
  logic      thrOn;
  logic      shutReg;

  // Hysteresis state for the hardware path
  always_comb begin
    hwStateNext = hwState;
    unique case (hwState)
      ST_COOL: if (atTrip)       hwStateNext = ST_HOT;
      ST_HOT:  if (belowRelease) hwStateNext = ST_COOL;
      default: hwStateNext = ST_COOL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwState <= ST_COOL;
      thrOn   <= 1'b0;
      shutReg <= 1'b0;
    end else begin
      hwState <= hwStateNext;
      thrOn   <= (hwStateNext == ST_HOT) || swThrottle;
      shutReg <= shutReg || atCrit;
    end
  end

  always_comb begin
    strobe.thrActive = thrOn;
    strobe.cntClear  = !thrOn;
    strobe.stopAll   = shutReg;
    procHot          = thrOn;
    shutdownReq      = shutReg;
  end

endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thr_pkg::*;
#(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HYST   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [TEMP_W-1:0] tripLevel,
  input  logic [TEMP_W-1:0] critLevel,
  input  logic [CNT_W-1:0]  periodLen,
  input  logic [CNT_W-1:0]  onLen,
  input  logic              swThrottle,
  output logic              coreClkEn,
  output logic              procHot,
  output logic              shutdownReq
);

  thrStrobe_t strobe;
  logic       atTrip;
  logic       belowRelease;
  logic       atCrit;

  thr_datapath #(
    .TEMP_W(TEMP_W),
    .CNT_W (CNT_W),
    .HYST  (HYST)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .tempCode    (tempCode),
    .tripLevel   (tripLevel),
    .critLevel   (critLevel),
    .periodLen   (periodLen),
    .onLen       (onLen),
    .strobe      (strobe),
    .atTrip      (atTrip),
    .belowRelease(belowRelease),
    .atCrit      (atCrit),
    .coreClkEn   (coreClkEn)
  );

  thr_control uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .atTrip      (atTrip),
    .belowRelease(belowRelease),
    .atCrit      (atCrit),
    .swThrottle  (swThrottle),
    .strobe      (strobe),
    .procHot     (procHot),
    .shutdownReq (shutdownReq)
  );

endmodule

// File: rtl/thermal_throttle_chk.sv
module thermal_throttle_chk #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned HYST   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [TEMP_W-1:0] tempCode,
  input logic [TEMP_W-1:0] tripLevel,
  input logic [TEMP_W-1:0] critLevel,
  input logic              swThrottle,
  input logic              coreClkEn,
  input logic              procHot,
  input logic              shutdownReq
);

  logic [TEMP_W:0] coldSum;
  logic            coldNow;
  always_comb begin
    coldSum = {1'b0, tempCode} + (TEMP_W + 1)'(HYST);
    coldNow = !swThrottle && (coldSum < {1'b0, tripLevel});
  end

  AST_TRIP_HOT: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode >= tripLevel) |=> procHot); // R2
  AST_COLD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    coldNow |=> !procHot); // R3
  AST_IDLE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (!procHot && !shutdownReq) |-> coreClkEn); // R5
  AST_SW_HOT: assert property (@(posedge clk) disable iff (!rstN)
    swThrottle |=> procHot); // R6
  AST_CRIT_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    (tempCode >= critLevel) |=> shutdownReq); // R7
  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> shutdownReq); // R7
  AST_SHUT_GATES: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> !coreClkEn); // R8

endmodule

bind thermal_throttle thermal_throttle_chk #(
  .TEMP_W(TEMP_W),
  .HYST  (HYST)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .tempCode   (tempCode),
  .tripLevel  (tripLevel),
  .critLevel  (critLevel),
  .swThrottle (swThrottle),
  .coreClkEn  (coreClkEn),
  .procHot    (procHot),
  .shutdownReq(shutdownReq)
);

// File: tb/sim_thermal_throttle.sv
`timescale 1ns/1ps
module sim_thermal_throttle;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tempCode = 8'd20;
  logic [7:0] tripLevel = 8'd100;
  logic [7:0] critLevel = 8'd150;
  logic [7:0] periodLen = 8'd4;
  logic [7:0] onLen = 8'd2;
  logic       swThrottle = 1'b0;
  logic       coreClkEn;
  logic       procHot;
  logic       shutdownReq;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  thermal_throttle u0 (
    .clk(clk), .rstN(rstN), .tempCode(tempCode), .tripLevel(tripLevel),
    .critLevel(critLevel), .periodLen(periodLen), .onLen(onLen),
    .swThrottle(swThrottle), .coreClkEn(coreClkEn), .procHot(procHot),
    .shutdownReq(shutdownReq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Advance one edge, then sample 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    swThrottle = 1'b0;
    tempCode = 8'd20;
    tripLevel = 8'd100;
    critLevel = 8'd150;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    step();
  endtask

  task automatic testReset();
    chk("R1", "coreClkEn", 32'(coreClkEn), 1);
    chk("R1", "procHot", 32'(procHot), 0);
    chk("R1", "shutdownReq", 32'(shutdownReq), 0);
  endtask

  task automatic testIdle();
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R5", "idle enable", 32'(coreClkEn), 1);
    end
  endtask

  task automatic testTripHyst();
    @(negedge clk); tempCode = 8'd100; step();
    chk("R2", "hot at trip", 32'(procHot), 1);
    @(negedge clk); tempCode = 8'd97; step();
    chk("R3", "held at 97", 32'(procHot), 1);
    @(negedge clk); tempCode = 8'd96; step();
    chk("R3", "held at 96", 32'(procHot), 1);
    @(negedge clk); tempCode = 8'd95; step();
    chk("R3", "release at 95", 32'(procHot), 0);
    chk("R5", "enable after release", 32'(coreClkEn), 1);
    @(negedge clk); tempCode = 8'd99; step();
    chk("R2", "stays cool below trip", 32'(procHot), 0);
  endtask

  task automatic runPattern(input string req, input int per, input int on, input int n);
    for (int j = 0; j < n; j++) begin
      logic expv;
      if (per <= 1) expv = (on > 0);
      else expv = ((j % per) < on);
      chk(req, $sformatf("duty cycle %0d", j), 32'(coreClkEn), 32'(expv));
      step();
    end
  endtask

  task automatic testDuty();
    @(negedge clk); periodLen = 8'd5; onLen = 8'd2; tempCode = 8'd110; step();
    runPattern("R4", 5, 2, 12);
    @(negedge clk); tempCode = 8'd20; step();
    chk("R4", "ends on cool", 32'(procHot), 0);
    @(negedge clk); periodLen = 8'd3; onLen = 8'd1; tempCode = 8'd120; step();
    runPattern("R4", 3, 1, 7);
    @(negedge clk); tempCode = 8'd20; step();
  endtask

  task automatic testDutyEdges();
    @(negedge clk); periodLen = 8'd4; onLen = 8'd4; tempCode = 8'd110; step();
    runPattern("R9", 4, 4, 6);
    @(negedge clk); tempCode = 8'd20; step();
    @(negedge clk); onLen = 8'd0; tempCode = 8'd110; step();
    runPattern("R9", 4, 0, 6);
    @(negedge clk); tempCode = 8'd20; step();
    chk("R9", "release", 32'(coreClkEn), 1);
  endtask

  task automatic testSw();
    @(negedge clk); periodLen = 8'd4; onLen = 8'd3; swThrottle = 1'b1; step();
    chk("R6", "sw hot", 32'(procHot), 1);
    runPattern("R6", 4, 3, 8);
    @(negedge clk); swThrottle = 1'b0; step();
    chk("R6", "sw release", 32'(procHot), 0);
  endtask

  task automatic testTripProg();
    @(negedge clk); tripLevel = 8'd50; tempCode = 8'd60; step();
    chk("R10", "hot vs low trip", 32'(procHot), 1);
    @(negedge clk); tripLevel = 8'd200; step();
    chk("R10", "released by raised trip", 32'(procHot), 0);
    @(negedge clk); tripLevel = 8'd100; tempCode = 8'd20; step();
  endtask

  task automatic testShutdown();
    @(negedge clk); periodLen = 8'd4; onLen = 8'd2; tempCode = 8'd160; step();
    chk("R7", "shutdown raised", 32'(shutdownReq), 1);
    chk("R8", "same-edge hot", 32'(procHot), 1);
    chk("R8", "enable off over duty", 32'(coreClkEn), 0);
    @(negedge clk); tempCode = 8'd20;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7", "sticky", 32'(shutdownReq), 1);
      chk("R8", "enable stays off", 32'(coreClkEn), 0);
    end
    doReset();
    chk("R1", "shutdown cleared", 32'(shutdownReq), 0);
    chk("R1", "enable back", 32'(coreClkEn), 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    doReset();
    testReset();
    testIdle();
    testTripHyst();
    testDuty();
    testDutyEdges();
    testSw();
    testTripProg();
    testShutdown();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule